// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device from power-on to a usable state. While reset is held, and for the whole sequence afterwards, it keeps the clock-enable pin high. Once reset is released it issues only NOP commands for a stabilization interval. That interval is given in microseconds and turned into a cycle count from the clock-frequency parameter.

After the wait, the block drives the fixed sequence the memory demands. First comes one precharge of every bank. Then come no fewer than two auto-refresh commands. Last comes a mode register load that places a caller-supplied mode word on the low address lines. The gaps after each command are parameters in clock cycles: the row precharge time after the precharge, the refresh cycle time after every refresh, and the mode-load delay after the mode register set. Every cycle between commands carries a NOP.

When the mode-load delay has passed, the done flag rises and stays high. From then on the outputs hold NOP until the next synchronous reset, which starts the whole sequence over. A memory controller would hold off its own traffic until the done flag is high. The parameters must satisfy: each gap is at least 2 cycles, the wait is at least 2 cycles, the address is wider than 10 bits, and the address is wider than the mode word.

Top module: `sdram_init_seq`

## Requirements
- R1: `sdCke` is 1 in every cycle while reset is asserted and in every cycle after it, through and beyond the sequence.
- R2: The wait length is WAIT_CYC = CLK_FREQ_MHZ * WAIT_US cycles; with the defaults this is 40000 cycles, or 200 us at 200 MHz. Counting from the first rising edge at which reset is sampled low, the outputs carry NOP after every edge before edge number WAIT_CYC. NOP is `sdCsN`=0 with {`sdRasN`,`sdCasN`,`sdWeN`}=3'b111.
- R3: The precharge-all command appears after edge number WAIT_CYC, and only once. It is encoded as `sdCsN`=0 and {ras,cas,we}=3'b010, with `sdAddr` bit 10 set to 1, every other address bit 0, and `sdBa`=0.
- R4: The number of auto-refresh commands is max(REFRESH_COUNT, 2), so a count below 2 gives exactly 2. Each is encoded as {ras,cas,we}=3'b001 with `sdAddr`=0 and `sdBa`=0. The first comes T_RP cycles after the precharge, and each later one comes T_RC cycles after the one before it.
- R5: The mode register set comes T_RC cycles after the last refresh. It is encoded as {ras,cas,we}=3'b000, with `sdAddr[MODE_WIDTH-1:0]`=`modeWord`, the upper address bits 0, and `sdBa`=0.
- R6: `initDone` is 0 until exactly T_MRD cycles after the mode register set, then becomes 1 and stays 1 until reset.
- R7: A synchronous reset at any point restarts the whole sequence. While reset is asserted the outputs carry NOP, `sdAddr` is 0 and `initDone` is 0.
- R8: Every output cycle that is not one of the listed commands carries NOP with zero address and bank, including all cycles after the done flag rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; restarts the sequence |
| modeWord | input | MODE_WIDTH | Value loaded by the mode register set; held stable during the sequence |
| sdCke | output | 1 | Clock enable to the memory, always high |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row address strobe, active low |
| sdCasN | output | 1 | Column address strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdAddr | output | ADDR_WIDTH | Address lines; bit 10 selects all banks on precharge |
| sdBa | output | BA_WIDTH | Bank address, 0 throughout |
| initDone | output | 1 | High once the sequence has finished |

## Verification
The full sequence is run with three mode words. The first is a typical burst and latency setting. The second is all ones, which shows that the upper address bits stay 0 during the mode load. The third is an alternating pattern, which exposes swapped or shifted address bits. A refresh count of 1 is configured to show that the count is raised to two refreshes. A reset in the middle of the refresh phase, after the precharge, tells a true restart apart from a resumed sequence: the precharge must reappear after the full wait. Every cycle outside the expected command slots is checked for NOP, so a command issued one cycle early or late is seen both as a wrong slot and as a stray command.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // Strobes from the sequencing control to the command datapath
  typedef struct packed {
    logic issuePre;
    logic issueRef;
    logic issueMrs;
    logic setDone;
  } initStrobe_t;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_PRE,
    ST_REF,
    ST_MRS,
    ST_GAP,
    ST_DONE
  } initState_t;

  // Command encodings as {rasN, casN, weN}, chip select low
  localparam logic [2:0] CMD_NOP = 3'b111;
  localparam logic [2:0] CMD_PRE = 3'b010;
  localparam logic [2:0] CMD_REF = 3'b001;
  localparam logic [2:0] CMD_MRS = 3'b000;

  // Address bit that selects every bank on precharge
  localparam int ALL_BANK_BIT = 10;

endpackage

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
#(
  parameter int WAIT_CYC = 40000,
  parameter int REF_N    = 2,
  parameter int T_RP     = 3,
  parameter int T_RC     = 9,
  parameter int T_MRD    = 2
) (
  input  logic        clk,
  input  logic        rst,
  output initStrobe_t strobe
);

  localparam int MAX_A   = (WAIT_CYC > T_RC) ? WAIT_CYC : T_RC;
  localparam int MAX_B   = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int MAX_CNT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam int REF_W   = $clog2(REF_N + 1);

  localparam logic [CNT_W-1:0] WAIT_LOAD = CNT_W'(WAIT_CYC - 2);
  localparam logic [CNT_W-1:0] RP_LOAD   = CNT_W'(T_RP - 2);
  localparam logic [CNT_W-1:0] RC_LOAD   = CNT_W'(T_RC - 2);
  localparam logic [CNT_W-1:0] MRD_LOAD  = CNT_W'(T_MRD - 2);

  initState_t       state;
  initState_t       gapTarget;
  logic [CNT_W-1:0] cnt;
  logic [REF_W-1:0] refLeft;

  // Step sequencing: each command state lasts one cycle, gaps count down
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_WAIT;
      gapTarget <= ST_PRE;
      cnt       <= WAIT_LOAD;
      refLeft   <= REF_W'(REF_N);
    end else begin
      case (state)
        ST_WAIT: begin
          if (cnt == '0) state <= ST_PRE;
          else           cnt   <= cnt - 1'b1;
        end
        ST_PRE: begin
          state     <= ST_GAP;
          cnt       <= RP_LOAD;
          gapTarget <= ST_REF;
        end
        ST_REF: begin
          state     <= ST_GAP;
          cnt       <= RC_LOAD;
          refLeft   <= refLeft - 1'b1;
          gapTarget <= (refLeft == REF_W'(1)) ? ST_MRS : ST_REF;
        end
        ST_MRS: begin
          state     <= ST_GAP;
          cnt       <= MRD_LOAD;
          gapTarget <= ST_DONE;
        end
        ST_GAP: begin
          if (cnt == '0) state <= gapTarget;
          else           cnt   <= cnt - 1'b1;
        end
        ST_DONE: state <= ST_DONE;
        default: state <= ST_WAIT;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.issuePre = (state == ST_PRE);
    strobe.issueRef = (state == ST_REF);
    strobe.issueMrs = (state == ST_MRS);
    strobe.setDone  = (state == ST_DONE);
  end

  // Ordering checks on the strobes against an independent tally
  logic             preSeen;
  logic [REF_W-1:0] refTally;

  always_ff @(posedge clk) begin
    if (rst) begin
      preSeen  <= 1'b0;
      refTally <= '0;
    end else begin
      if (strobe.issuePre) preSeen <= 1'b1;
      if (strobe.issueRef && refTally != REF_W'(REF_N)) refTally <= refTally + 1'b1;
    end
  end

  assert_pre_once_R3: assert property (@(posedge clk) disable iff (rst)
    strobe.issuePre |-> !preSeen);

  assert_ref_after_pre_R4: assert property (@(posedge clk) disable iff (rst)
    strobe.issueRef |-> preSeen);

  assert_mrs_after_refs_R5: assert property (@(posedge clk) disable iff (rst)
    strobe.issueMrs |-> (refTally >= REF_W'(2)));

  assert_single_command_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.issuePre, strobe.issueRef, strobe.issueMrs}));

endmodule

// File: rtl/sdram_init_dp.sv
module sdram_init_dp
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int MODE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  initStrobe_t       strobe,
  input  logic [MODE_W-1:0] modeWord,
  output logic              sdCke,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [ADDR_W-1:0] sdAddr,
  output logic [BA_W-1:0]   sdBa,
  output logic              initDone
);

  localparam logic [ADDR_W-1:0] PRE_ADDR = ADDR_W'(1) << ALL_BANK_BIT;

  logic [2:0]        cmdQ;
  logic [ADDR_W-1:0] addrQ;
  logic              doneQ;
  logic              ckeQ;

  // Registered command, address and status drive the pins
  always_ff @(posedge clk) begin
    if (rst) begin
      cmdQ  <= CMD_NOP;
      addrQ <= '0;
      doneQ <= 1'b0;
      ckeQ  <= 1'b1;
    end else begin
      ckeQ  <= 1'b1;
      doneQ <= doneQ | strobe.setDone;
      if (strobe.issuePre) begin
        cmdQ  <= CMD_PRE;
        addrQ <= PRE_ADDR;
      end else if (strobe.issueRef) begin
        cmdQ  <= CMD_REF;
        addrQ <= '0;
      end else if (strobe.issueMrs) begin
        cmdQ  <= CMD_MRS;
        addrQ <= ADDR_W'(modeWord);
      end else begin
        cmdQ  <= CMD_NOP;
        addrQ <= '0;
      end
    end
  end

  assign sdCke    = ckeQ;
  assign sdCsN    = 1'b0;
  assign {sdRasN, sdCasN, sdWeN} = cmdQ;
  assign sdAddr   = addrQ;
  assign sdBa     = '0;
  assign initDone = doneQ;

  // Pin-side history for the done checks
  logic mrsOut;
  always_ff @(posedge clk) begin
    if (rst)                  mrsOut <= 1'b0;
    else if (cmdQ == CMD_MRS) mrsOut <= 1'b1;
  end

  assert_cke_high_R1: assert property (@(posedge clk) disable iff (rst)
    sdCke);

  assert_done_after_mrs_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(initDone) |-> mrsOut);

  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    initDone |=> initDone);

  assert_nop_after_done_R8: assert property (@(posedge clk) disable iff (rst)
    initDone |-> (cmdQ == CMD_NOP));

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_FREQ_MHZ  = 200,
  parameter int WAIT_US       = 200,
  parameter int REFRESH_COUNT = 2,
  parameter int T_RP          = 3,
  parameter int T_RC          = 9,
  parameter int T_MRD         = 2,
  parameter int ADDR_WIDTH    = 13,
  parameter int BA_WIDTH      = 2,
  parameter int MODE_WIDTH    = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [MODE_WIDTH-1:0] modeWord,
  output logic                  sdCke,
  output logic                  sdCsN,
  output logic                  sdRasN,
  output logic                  sdCasN,
  output logic                  sdWeN,
  output logic [ADDR_WIDTH-1:0] sdAddr,
  output logic [BA_WIDTH-1:0]   sdBa,
  output logic                  initDone
);

  localparam int WAIT_CYC = CLK_FREQ_MHZ * WAIT_US;
  localparam int REF_N    = (REFRESH_COUNT < 2) ? 2 : REFRESH_COUNT;

  initStrobe_t strobe;

  sdram_init_ctrl #(
    .WAIT_CYC (WAIT_CYC),
    .REF_N    (REF_N),
    .T_RP     (T_RP),
    .T_RC     (T_RC),
    .T_MRD    (T_MRD)
  ) i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe)
  );

  sdram_init_dp #(
    .ADDR_W (ADDR_WIDTH),
    .BA_W   (BA_WIDTH),
    .MODE_W (MODE_WIDTH)
  ) i_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .modeWord (modeWord),
    .sdCke    (sdCke),
    .sdCsN    (sdCsN),
    .sdRasN   (sdRasN),
    .sdCasN   (sdCasN),
    .sdWeN    (sdWeN),
    .sdAddr   (sdAddr),
    .sdBa     (sdBa),
    .initDone (initDone)
  );

endmodule

// File: tb/test_sdram_init_seq.sv
`timescale 1ns/1ps
module test_sdram_init_seq;

  localparam int FREQ  = 200;
  localparam int WUS   = 1;
  localparam int RP    = 3;
  localparam int RC    = 5;
  localparam int MRD   = 4;
  localparam int AW    = 13;
  localparam int MW    = 10;
  localparam int W     = FREQ * WUS;
  localparam int EV_N  = 4;

  // Expected command slots: edge number and {ras,cas,we}
  localparam int         evEdge [EV_N] = '{W, W + RP, W + RP + RC, W + RP + 2 * RC};
  localparam logic [2:0] evCmd  [EV_N] = '{3'b010, 3'b001, 3'b001, 3'b000};
  localparam int DONE_EDGE = W + RP + 2 * RC + MRD;
  localparam int FULL_RUN  = DONE_EDGE + 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [MW-1:0] modeWord = '0;
  logic          sdCke, sdCsN, sdRasN, sdCasN, sdWeN, initDone;
  logic [AW-1:0] sdAddr;
  logic [1:0]    sdBa;

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  sdram_init_seq #(
    .CLK_FREQ_MHZ (FREQ), .WAIT_US (WUS), .REFRESH_COUNT (1),
    .T_RP (RP), .T_RC (RC), .T_MRD (MRD),
    .ADDR_WIDTH (AW), .BA_WIDTH (2), .MODE_WIDTH (MW)
  ) i_sdram_init_seq (
    .clk (clk), .rst (rst), .modeWord (modeWord),
    .sdCke (sdCke), .sdCsN (sdCsN), .sdRasN (sdRasN), .sdCasN (sdCasN),
    .sdWeN (sdWeN), .sdAddr (sdAddr), .sdBa (sdBa), .initDone (initDone)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Reset, release, then walk the expected-slot table edge by edge
  task automatic runSeq(input logic [MW-1:0] mv, input int stopAt);
    int nopBad = 0, ckeBad = 0, early = 0, late = 0, refSeen = 0;
    logic [AW-1:0] expAddr;
    modeWord = mv;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check({sdCsN, sdRasN, sdCasN, sdWeN} == 4'b0111, "R7 reset command NOP",
          {sdCsN, sdRasN, sdCasN, sdWeN}, 4'b0111);
    check(initDone == 1'b0 && sdAddr == '0, "R7 reset done/addr clear",
          {initDone, sdAddr}, 0);
    check(sdCke == 1'b1, "R1 cke during reset", sdCke, 1);
    rst = 1'b0;
    for (int n = 1; n <= stopAt; n++) begin
      int hit = -1;
      @(negedge clk);
      if (!sdCke) ckeBad++;
      for (int e = 0; e < EV_N; e++) if (evEdge[e] == n) hit = e;
      if (hit >= 0) begin
        expAddr = (evCmd[hit] == 3'b010) ? AW'(1) << 10 :
                  (evCmd[hit] == 3'b000) ? AW'(mv) : '0;
        if (evCmd[hit] == 3'b001) refSeen += ({sdRasN, sdCasN, sdWeN} == 3'b001);
        check({sdCsN, sdRasN, sdCasN, sdWeN} == {1'b0, evCmd[hit]},
              (evCmd[hit] == 3'b010) ? "R3 precharge command" :
              (evCmd[hit] == 3'b001) ? "R4 refresh command" : "R5 mode set command",
              {sdCsN, sdRasN, sdCasN, sdWeN}, {1'b0, evCmd[hit]});
        check(sdAddr == expAddr && sdBa == 2'b00,
              (evCmd[hit] == 3'b010) ? "R3 precharge address" :
              (evCmd[hit] == 3'b001) ? "R4 refresh address" : "R5 mode word address",
              {sdBa, sdAddr}, expAddr);
      end else if ({sdCsN, sdRasN, sdCasN, sdWeN} != 4'b0111 || sdAddr != '0 || sdBa != '0) begin
        nopBad++;
      end
      if (n < DONE_EDGE && initDone) early++;
      if (n >= DONE_EDGE && !initDone) late++;
    end
    check(nopBad == 0, "R2 R8 NOP outside command slots", nopBad, 0);
    check(ckeBad == 0, "R1 cke high after reset", ckeBad, 0);
    check(early == 0, "R6 done low before delay", early, 0);
    if (stopAt >= DONE_EDGE) begin
      check(late == 0, "R6 done high and held", late, 0);
      check(refSeen == 2, "R4 refresh count clamped to two", refSeen, 2);
    end
  endtask

  initial begin
    runSeq(10'h032, FULL_RUN);
    runSeq(10'h3FF, FULL_RUN);
    runSeq(10'h155, FULL_RUN);
    // Reset during refresh phase, then the sequence must restart from the wait
    runSeq(10'h2AA, W + RP + 2);
    runSeq(10'h2AA, FULL_RUN);   // R7 restart timing
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule